// File: doc/BRIEF.md
# Accumulator ALU with condition codes

This block is the arithmetic and logic core of a small accumulator machine that works on either 8-bit or 16-bit data. Each cycle it receives an operation code, a width select, the accumulator value X and a second operand M. It returns a result, a write-back strobe that says whether the result should be written back, and a registered 4-bit condition code: negative, zero, signed overflow and carry.

The operations are add, subtract, compare, test against zero, increment, decrement, AND, OR, XOR, complement, bit test, shifts and rotates, and a plain pass-through for load and store traffic. Each class has its own rule for which flags it updates. The flag register can also have C or V set or cleared directly. It can be loaded from the low bits of X, or read out as a result. Rotates take their incoming carry from the registered C flag. Instruction decode, memory access and branching sit outside the block.

Top module: `acc_alu`

## Requirements
- R1: The flag register output is {N,Z,V,C} on bits 3..0, and it is 0 after reset. The op_i codes are: 0 pass, 1 add, 2 sub, 3 cmp, 4 tst, 5 inc, 6 dec, 7 and, 8 or, 9 xor, 10 com, 11 bit, 12 shift left, 13 arithmetic shift right, 14 logical shift right, 15 rotate left, 16 rotate right, 17 clear C, 18 set C, 19 clear V, 20 set V, 21 load flags from X, 22 read flags.
- R2: With wide_i=0 only bits 7:0 of the operands are used, res_o[15:8] is 0, and N is bit 7 of the result. With wide_i=1 all 16 bits are used and N is bit 15. Z is set when the result at the selected width is zero.
- R3: Add returns X+M. V is set on two's-complement overflow, C is the unsigned carry out, and N and Z follow the result.
- R4: Sub returns X−M. C is set on an unsigned borrow, V on signed overflow, and N and Z follow the result. Cmp updates the same flags but drives wr_o=0. Tst takes M as 0 and also drives wr_o=0, so it leaves V=0 and C=0.
- R5: Inc and dec return X+1 and X−1, wrapping at the selected width. They update only Z; N, V and C keep their values.
- R6: And, or, xor, complement and bit test set N and Z from the result, clear V and keep C. Complement returns the all-ones value minus X. Bit test computes X AND M with wr_o=0.
- R7: Pass returns X with wr_o=1, sets N and Z from it, clears V and keeps C.
- R8: Shift left doubles X. Arithmetic shift right keeps the sign bit, and logical shift right brings in 0. C receives the bit shifted out. V is set when the result's sign bit differs from X's, and N and Z follow the result.
- R9: Rotate left moves the stored C into bit 0 and the old sign bit into C. Rotate right moves the stored C into the sign bit and the old bit 0 into C. N, Z and V follow the rules of R8.
- R10: Clear C, set C, clear V and set V change only the named flag, and they drive wr_o=0.
- R11: Load flags copies x_i[3:0] into the flag register with wr_o=0. Read flags returns the flag register zero-extended on res_o with wr_o=1, and the flags stay unchanged.
- R12: The flag register changes only on a clock edge that has we_i=1. With we_i=0 every flag keeps its value whatever the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 5 | Operation code |
| wide_i | input | 1 | 1 selects 16-bit, 0 selects 8-bit |
| x_i | input | 16 | Accumulator operand |
| m_i | input | 16 | Second operand |
| we_i | input | 1 | Flag register write enable |
| res_o | output | 16 | Result, combinational |
| wr_o | output | 1 | Result is to be written back |
| flags_o | output | 4 | Registered {N,Z,V,C} |

## Verification
The hardest case to reach is a rotate or a flag-preserving operation that runs with a carry left by an unrelated earlier operation. This is what separates a correct flag register from one that resets or rebuilds flags it does not own. The bench never reloads the flags between vectors. Each sweep lets the flag state carry over from the previous operation, and we_i drops on a regular pattern, so the rotates, inc/dec and logic ops run against many stored N, Z, V and C combinations. The 8-bit sweep covers every X value against sixteen spread M values for every opcode. The 16-bit sweep pairs sign and carry corner values.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;
  parameter int unsigned WORD_W = 16;
  parameter int unsigned BYTE_W = 8;
  parameter int unsigned FLAG_W = 4;
  parameter int unsigned OP_W   = 5;

  typedef enum logic [OP_W-1:0] {
    OP_PASS = 5'd0,  OP_ADD = 5'd1,  OP_SUB = 5'd2,  OP_CMP = 5'd3,
    OP_TST  = 5'd4,  OP_INC = 5'd5,  OP_DEC = 5'd6,  OP_AND = 5'd7,
    OP_OR   = 5'd8,  OP_XOR = 5'd9,  OP_COM = 5'd10, OP_BIT = 5'd11,
    OP_ASL  = 5'd12, OP_ASR = 5'd13, OP_LSR = 5'd14, OP_ROL = 5'd15,
    OP_ROR  = 5'd16, OP_CLC = 5'd17, OP_SEC = 5'd18, OP_CLV = 5'd19,
    OP_SEV  = 5'd20, OP_LDF = 5'd21, OP_RDF = 5'd22
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;
endpackage

// File: rtl/acc_alu_arith.sv
`timescale 1ns/1ps
module acc_alu_arith import acc_alu_pkg::*; #(
  parameter int unsigned W = WORD_W,
  parameter int unsigned B = BYTE_W
) (
  input  alu_op_e      op_i,
  input  logic         wide_i,
  input  logic [W-1:0] wmask_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         v_o,
  output logic         c_o
);
  logic         sub;
  logic [W-1:0] opnd;
  logic [W:0]   full;
  logic         am, om, rm;

  always_comb begin
    sub  = 1'b0;
    opnd = b_i;
    case (op_i)
      OP_SUB, OP_CMP: sub = 1'b1;
      OP_TST: begin sub = 1'b1; opnd = '0; end
      OP_INC: opnd = W'(1);
      OP_DEC: begin sub = 1'b1; opnd = W'(1); end
      default: ;
    endcase
  end

  assign full  = sub ? ({1'b0, a_i} - {1'b0, opnd}) : ({1'b0, a_i} + {1'b0, opnd});
  assign res_o = full[W-1:0] & wmask_i;

  // sign bits at selected width
  assign am = wide_i ? a_i[W-1]   : a_i[B-1];
  assign om = wide_i ? opnd[W-1]  : opnd[B-1];
  assign rm = wide_i ? res_o[W-1] : res_o[B-1];

  always_comb begin
    if (sub) begin
      v_o = (am & ~om & ~rm) | (~am & om & rm);
      c_o = (~am & om) | (om & rm) | (rm & ~am);
    end else begin
      v_o = (am & om & ~rm) | (~am & ~om & rm);
      c_o = (am & om) | (om & ~rm) | (~rm & am);
    end
  end
endmodule

// File: rtl/acc_alu_logic.sv
`timescale 1ns/1ps
module acc_alu_logic import acc_alu_pkg::*; #(
  parameter int unsigned W = WORD_W
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] wmask_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    case (op_i)
      OP_AND, OP_BIT: res_o = a_i & b_i;
      OP_OR:          res_o = a_i | b_i;
      OP_XOR:         res_o = a_i ^ b_i;
      OP_COM:         res_o = wmask_i - a_i;
      default:        res_o = a_i;
    endcase
  end
endmodule

// File: rtl/acc_alu_shift.sv
`timescale 1ns/1ps
module acc_alu_shift import acc_alu_pkg::*; #(
  parameter int unsigned W = WORD_W,
  parameter int unsigned B = BYTE_W
) (
  input  alu_op_e      op_i,
  input  logic         wide_i,
  input  logic [W-1:0] wmask_i,
  input  logic [W-1:0] a_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         v_o,
  output logic         c_o
);
  localparam int unsigned IDX_W = $clog2(W);
  localparam logic [IDX_W-1:0] TOP_W = IDX_W'(W - 1);
  localparam logic [IDX_W-1:0] TOP_B = IDX_W'(B - 1);

  logic [IDX_W-1:0] top_idx;
  logic [W-1:0]     r;
  logic             top;

  assign top_idx = wide_i ? TOP_W : TOP_B;
  assign top     = a_i[top_idx];

  always_comb begin
    r   = a_i >> 1;
    c_o = a_i[0];
    case (op_i)
      OP_ASL: begin r = a_i << 1; c_o = top; end
      OP_ROL: begin r = (a_i << 1) | {{(W-1){1'b0}}, cin_i}; c_o = top; end
      OP_ASR: r[top_idx] = top;
      OP_ROR: r[top_idx] = cin_i;
      default: ;
    endcase
  end

  assign res_o = r & wmask_i;
  assign v_o   = top ^ res_o[top_idx];
endmodule

// File: rtl/acc_alu_flags.sv
`timescale 1ns/1ps
module acc_alu_flags import acc_alu_pkg::*; #(
  parameter int unsigned N = FLAG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [N-1:0] upd_i,
  input  logic [N-1:0] nxt_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                q_o[i] <= 1'b0;
      else if (we_i && upd_i[i])  q_o[i] <= nxt_i[i];
    end
  end

  assert_hold_when_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));

  assert_unowned_stable_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && upd_i == '0) |=> $stable(q_o));
endmodule

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu import acc_alu_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   op_i,
  input  logic              wide_i,
  input  logic [WORD_W-1:0] x_i,
  input  logic [WORD_W-1:0] m_i,
  input  logic              we_i,
  output logic [WORD_W-1:0] res_o,
  output logic              wr_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam int unsigned W = WORD_W;
  localparam int unsigned B = BYTE_W;
  localparam logic [W-1:0] NARROW_MASK = {{(W-B){1'b0}}, {B{1'b1}}};

  alu_op_e      op;
  logic [W-1:0] wmask, xa, ma;
  logic [W-1:0] ar_res, lg_res, sh_res;
  logic         ar_v, ar_c, sh_v, sh_c;
  logic         n_res, z_res;
  flags_t       cur, nxt, upd;

  assign op    = alu_op_e'(op_i);
  assign wmask = wide_i ? '1 : NARROW_MASK;
  assign xa    = x_i & wmask;
  assign ma    = m_i & wmask;
  assign cur   = flags_t'(flags_o);

  acc_alu_arith #(.W(W), .B(B)) i_arith (
    .op_i(op), .wide_i(wide_i), .wmask_i(wmask), .a_i(xa), .b_i(ma),
    .res_o(ar_res), .v_o(ar_v), .c_o(ar_c));

  acc_alu_logic #(.W(W)) i_logic (
    .op_i(op), .wmask_i(wmask), .a_i(xa), .b_i(ma), .res_o(lg_res));

  acc_alu_shift #(.W(W), .B(B)) i_shift (
    .op_i(op), .wide_i(wide_i), .wmask_i(wmask), .a_i(xa), .cin_i(cur.c),
    .res_o(sh_res), .v_o(sh_v), .c_o(sh_c));

  always_comb begin
    res_o = '0;
    wr_o  = 1'b0;
    case (op)
      OP_PASS:                          begin res_o = xa;     wr_o = 1'b1; end
      OP_ADD, OP_SUB, OP_INC, OP_DEC:   begin res_o = ar_res; wr_o = 1'b1; end
      OP_CMP, OP_TST:                         res_o = ar_res;
      OP_AND, OP_OR, OP_XOR, OP_COM:    begin res_o = lg_res; wr_o = 1'b1; end
      OP_BIT:                                 res_o = lg_res;
      OP_ASL, OP_ASR, OP_LSR, OP_ROL, OP_ROR:
                                        begin res_o = sh_res; wr_o = 1'b1; end
      OP_RDF: begin res_o = {{(W-FLAG_W){1'b0}}, flags_o}; wr_o = 1'b1; end
      default: ;
    endcase
  end

  assign n_res = wide_i ? res_o[W-1] : res_o[B-1];
  assign z_res = ~|res_o;

  always_comb begin
    upd   = '0;
    nxt   = cur;
    nxt.n = n_res;
    nxt.z = z_res;
    case (op)
      OP_PASS, OP_AND, OP_OR, OP_XOR, OP_COM, OP_BIT: begin
        upd = 4'b1110; nxt.v = 1'b0;
      end
      OP_ADD, OP_SUB, OP_CMP, OP_TST: begin
        upd = 4'b1111; nxt.v = ar_v; nxt.c = ar_c;
      end
      OP_INC, OP_DEC: upd = 4'b0100;
      OP_ASL, OP_ASR, OP_LSR, OP_ROL, OP_ROR: begin
        upd = 4'b1111; nxt.v = sh_v; nxt.c = sh_c;
      end
      OP_CLC: begin upd = 4'b0001; nxt.c = 1'b0; end
      OP_SEC: begin upd = 4'b0001; nxt.c = 1'b1; end
      OP_CLV: begin upd = 4'b0010; nxt.v = 1'b0; end
      OP_SEV: begin upd = 4'b0010; nxt.v = 1'b1; end
      OP_LDF: begin upd = 4'b1111; nxt = flags_t'(x_i[FLAG_W-1:0]); end
      default: ;
    endcase
  end

  acc_alu_flags #(.N(FLAG_W)) i_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i),
    .upd_i(upd), .nxt_i(nxt), .q_o(flags_o));

  // carry check against a plain wider add
  logic [W:0] add_chk;
  assign add_chk = {1'b0, xa} + {1'b0, ma};

  assert_add_carry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_ADD) |-> (ar_c == (wide_i ? add_chk[W] : add_chk[B])));

  assert_narrow_upper_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wide_i && op != OP_RDF) |-> (res_o[W-1:B] == '0));

  assert_step_only_z_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (op == OP_INC || op == OP_DEC)) |=>
      ($stable(flags_o[3]) && $stable(flags_o[1]) && $stable(flags_o[0])));

  assert_logic_clears_v_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (op == OP_AND || op == OP_OR || op == OP_XOR || op == OP_COM || op == OP_BIT))
      |=> !flags_o[1]);

  assert_set_carry_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && op == OP_SEC) |=> (flags_o[0] && $stable(flags_o[3:1])));

  assert_read_flags_keep_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_RDF) |=> $stable(flags_o));
endmodule

// File: tb/test_acc_alu.sv
`timescale 1ns/1ps
module test_acc_alu;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  op;
  logic        wide;
  logic [15:0] x, m;
  logic        we;
  logic [15:0] res;
  logic        wr;
  logic [3:0]  flags;

  int errors = 0;
  int checks = 0;
  int exp_f  = 0;

  always #10 clk = ~clk;

  acc_alu i_acc_alu (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .wide_i(wide), .x_i(x), .m_i(m),
    .we_i(we), .res_o(res), .wr_o(wr), .flags_o(flags));

  function automatic int sgn(input int v, input int w);
    return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
  endfunction

  function automatic int ovf(input int s, input int w);
    return (s < -(1 << (w - 1)) || s > (1 << (w - 1)) - 1) ? 1 : 0;
  endfunction

  function automatic string req_tag(input int o);
    case (o)
      0: return "R7";
      1: return "R3";
      2, 3, 4: return "R4";
      5, 6: return "R5";
      7, 8, 9, 10, 11: return "R6";
      12, 13, 14: return "R8";
      15, 16: return "R9";
      17, 18, 19, 20: return "R10";
      default: return "R11";
    endcase
  endfunction

  // reference model; flag bits n=8 z=4 v=2 c=1
  task automatic model(input int o, input int wd, input int xv, input int mv, input int f,
                       output int r, output int w_exp, output int nf);
    int w, mask, msb, xs, ms, nn, zz, vv, cc, full, setnz;
    w = wd ? 16 : 8; mask = (1 << w) - 1; msb = 1 << (w - 1);
    xs = xv & mask; ms = mv & mask;
    nn = (f >> 3) & 1; zz = (f >> 2) & 1; vv = (f >> 1) & 1; cc = f & 1;
    r = 0; w_exp = 0; setnz = 0;
    case (o)
      0: begin r = xs; w_exp = 1; setnz = 1; vv = 0; end
      1: begin full = xs + ms; r = full & mask; cc = (full > mask);
               vv = ovf(sgn(xs, w) + sgn(ms, w), w); w_exp = 1; setnz = 1; end
      2, 3: begin full = xs - ms; r = full & mask; cc = (xs < ms);
               vv = ovf(sgn(xs, w) - sgn(ms, w), w); w_exp = (o == 2); setnz = 1; end
      4: begin r = xs; cc = 0; vv = 0; setnz = 1; end
      5: begin r = (xs + 1) & mask; zz = (r == 0); w_exp = 1; end
      6: begin r = (xs - 1) & mask; zz = (r == 0); w_exp = 1; end
      7, 11: begin r = xs & ms; vv = 0; setnz = 1; w_exp = (o == 7); end
      8: begin r = xs | ms; vv = 0; setnz = 1; w_exp = 1; end
      9: begin r = xs ^ ms; vv = 0; setnz = 1; w_exp = 1; end
      10: begin r = mask - xs; vv = 0; setnz = 1; w_exp = 1; end
      12, 13, 14, 15, 16: begin
        case (o)
          12: begin r = (xs << 1) & mask; end
          13: begin r = (xs >> 1) | (xs & msb); end
          14: begin r = xs >> 1; end
          15: begin r = ((xs << 1) & mask) | cc; end
          default: begin r = (xs >> 1) | (cc ? msb : 0); end
        endcase
        cc = (o == 12 || o == 15) ? ((xs & msb) != 0) : (xs & 1);
        vv = (((xs & msb) != 0) != ((r & msb) != 0));
        setnz = 1; w_exp = 1;
      end
      17: cc = 0;
      18: cc = 1;
      19: vv = 0;
      20: vv = 1;
      21: begin nn = (xv >> 3) & 1; zz = (xv >> 2) & 1; vv = (xv >> 1) & 1; cc = xv & 1; end
      default: begin r = f; w_exp = 1; end
    endcase
    if (setnz) begin nn = ((r & msb) != 0); zz = (r == 0); end
    nf = (nn << 3) | (zz << 2) | (vv << 1) | cc;
  endtask

  task automatic do_vec(input int o, input int wd, input int xv, input int mv,
                        input int wen, input string tag);
    int r, w_exp, nf;
    @(negedge clk);
    op = o[4:0]; wide = wd[0]; x = xv[15:0]; m = mv[15:0]; we = wen[0];
    model(o, wd, xv, mv, exp_f, r, w_exp, nf);
    #5;
    // R2: narrow results compare as full 16-bit words, upper byte zero
    checks++;
    if (wr !== w_exp[0] || (w_exp == 1 && res !== r[15:0])) begin
      errors++;
      $display("FAIL %s op=%0d wide=%0d x=%h m=%h: res=%h wr=%b expected res=%h wr=%0d",
               tag, o, wd, xv[15:0], mv[15:0], res, wr, r[15:0], w_exp);
    end
    @(posedge clk); #1;
    if (wen) exp_f = nf;
    checks++;
    if (flags !== exp_f[3:0]) begin
      errors++;
      $display("FAIL %s op=%0d wide=%0d x=%h m=%h we=%0d: flags=%b expected %b",
               tag, o, wd, xv[15:0], mv[15:0], wen, flags, exp_f[3:0]);
    end
  endtask

  function automatic int corner(input int i);
    case (i)
      0: return 16'h0000; 1: return 16'h0001; 2: return 16'h7FFF;
      3: return 16'h8000; 4: return 16'hFFFF; 5: return 16'h00FF;
      6: return 16'h0100; 7: return 16'h5555; 8: return 16'hAAAA;
      default: return 16'h8001;
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op = '0; wide = 1'b0; x = '0; m = '0; we = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (flags !== 4'b0000) begin
      errors++;
      $display("FAIL R12 reset flags=%b expected 0000", flags);
    end
    @(negedge clk); rst_n = 1'b1;

    // R1: flag bit layout N,Z,V,C on 3..0
    do_vec(21, 0, 16'h0008, 0, 1, "R1");
    do_vec(22, 0, 0, 0, 1, "R1");
    do_vec(21, 1, 16'hFFF1, 0, 1, "R1");
    do_vec(22, 1, 0, 0, 0, "R1");

    for (int o = 0; o < 23; o++)
      for (int xv = 0; xv < 256; xv++)
        for (int mi = 0; mi < 16; mi++) begin
          int wen;
          wen = ((xv + mi + o) % 7 != 0) ? 1 : 0;
          do_vec(o, 0, xv, (mi * 17) ^ (xv & 8'h0F), wen, wen ? req_tag(o) : "R12");
        end

    for (int o = 0; o < 23; o++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 10; j++) begin
          int wen;
          wen = ((i + j) % 5 != 4) ? 1 : 0;
          do_vec(o, 1, corner(i), corner(j), wen, wen ? req_tag(o) : "R12");
        end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule